// File: doc/BRIEF.md
# Round-Robin Shadow Stripe Allocator

This block sits at the issue stage of an in-order-commit scheduler. Each cycle the issue logic presents a count of instructions that want shadow stripes. The block places them into consecutive stripes, starting at a rotating stripe pointer that wraps at the stripe count. It also gives each instruction a register-file write-port tag from a second rotating counter that wraps at the write-port count. Because the two counters have different moduli, the stripe count can exceed the number of write ports. The write port is therefore fixed at issue time, and commit does not need a priority picker across ports.

A stripe that has been loaded stays busy until the retirement logic pulses its release bit. Suppose the consecutive run of stripes that a request needs contains any busy stripe. The block then stalls, loads nothing and leaves both counters unchanged for that cycle. The load strobes, tags and stall are combinational from the current request and the registered state. Pointer and busy updates take effect at the next rising clock edge.

The block has no state machine. Its state is the two round-robin counters and one busy bit per stripe.

Top module: `shadow_stripe_alloc`

## Requirements
- R1: After reset both counters are zero and every stripe is free, so the first request of k instructions loads stripes 0..k-1 with port tags 0..k-1 without stall.
- R2: When not stalled, a request of k instructions raises exactly k load strobes, on stripes (p+j) mod NUM_STRIPES for j = 0..k-1, where p is the stripe pointer.
- R3: The stripe pointer advances by the accepted count modulo NUM_STRIPES and is always below NUM_STRIPES.
- R4: The stripe loaded at offset j gets port tag (q+j) mod NUM_PORTS, where q is the port counter. The port counter advances by the accepted count modulo NUM_PORTS. Stripe i's tag occupies bits [i*PW +: PW] of the tag bus, with PW = clog2(NUM_PORTS).
- R5: If any stripe in the needed run is busy, stall_o is high, no load strobe is raised, and neither counter moves.
- R6: A loaded stripe is busy from the next cycle until a cycle after its release bit is sampled high; a stall caused by it clears one cycle after the release.
- R7: A release bit for a stripe that is already free has no effect on the counters or any stripe.
- R8: A request of zero loads nothing, never stalls and leaves both counters unchanged.
- R9: A request count above MAX_ISSUE is treated as MAX_ISSUE.
- R10: The tag field of any stripe not loaded this cycle reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_cnt_i | input | clog2(MAX_ISSUE+1) | Number of instructions requesting stripes this cycle |
| release_i | input | NUM_STRIPES | Per-stripe release pulse from retirement |
| load_o | output | NUM_STRIPES | Per-stripe load strobe for this cycle |
| port_tag_o | output | NUM_STRIPES*clog2(NUM_PORTS) | Per-stripe write-port tag, valid where load_o is set |
| stall_o | output | 1 | Request cannot be placed this cycle |

## Verification
A wrong stripe pointer shows in the very next cycle that requests anything, as load strobes on the wrong stripes. A wrong port counter shows the same way, as shifted tags. A busy bit that is wrongly set or cleared only shows once the pointer comes back round to that stripe. It then appears as a stall that should not happen, or as a load onto a stripe still holding an entry. The bench runs a long mixed sequence so that the pointer wraps many times against random release patterns. It compares strobes, tags and stall against a behavioural model in every cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;
    function automatic int width_of(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sa_rr_ptr.sv
module sa_rr_ptr #(
    parameter int MODULUS = 6,
    parameter int PTR_W   = 3,
    parameter int STEP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    output logic [PTR_W-1:0]  ptr_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = PTR_W'((int'(ptr_q) + int'(step_i)) % MODULUS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < MODULUS); // R3
    AST_PTR_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/sa_slot.sv
module sa_slot #(
    parameter int NUM_STRIPES = 6,
    parameter int NUM_PORTS   = 4,
    parameter int SW          = 3,
    parameter int PW          = 2,
    parameter int CW          = 3,
    parameter int IDX         = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] stripe_ptr_i,
    input  logic [PW-1:0] port_ptr_i,
    input  logic [CW-1:0] eff_cnt_i,
    input  logic          grant_i,
    input  logic          release_i,
    output logic          want_o,
    output logic          busy_o,
    output logic          load_o,
    output logic [PW-1:0] tag_o
);
    int   offset;
    logic busy_q;

    always_comb begin
        offset = (IDX + NUM_STRIPES - int'(stripe_ptr_i)) % NUM_STRIPES;
        want_o = offset < int'(eff_cnt_i);
        load_o = want_o && grant_i;
        tag_o  = load_o ? PW'((int'(port_ptr_i) + offset) % NUM_PORTS) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= (busy_q && !release_i) || load_o;
    end

    assign busy_o = busy_q;

    AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !busy_q); // R6
    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> busy_q); // R6
    AST_FREE_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !load_o) |=> !busy_q); // R7
endmodule

// File: rtl/shadow_stripe_alloc.sv
module shadow_stripe_alloc #(
    parameter int NUM_STRIPES = 6,
    parameter int NUM_PORTS   = 4,
    parameter int MAX_ISSUE   = 4,
    localparam int SW = sa_pkg::width_of(NUM_STRIPES),
    localparam int PW = sa_pkg::width_of(NUM_PORTS),
    localparam int CW = sa_pkg::width_of(MAX_ISSUE + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             issue_cnt_i,
    input  logic [NUM_STRIPES-1:0]    release_i,
    output logic [NUM_STRIPES-1:0]    load_o,
    output logic [NUM_STRIPES*PW-1:0] port_tag_o,
    output logic                      stall_o
);
    logic [CW-1:0]          eff_cnt;
    logic [CW-1:0]          step;
    logic [SW-1:0]          stripe_ptr;
    logic [PW-1:0]          port_ptr;
    logic [NUM_STRIPES-1:0] want;
    logic [NUM_STRIPES-1:0] busy;
    logic                   grant;

    always_comb begin
        eff_cnt = (int'(issue_cnt_i) > MAX_ISSUE) ? CW'(MAX_ISSUE) : issue_cnt_i;
        stall_o = |(want & busy);
        grant   = !stall_o;
        step    = grant ? eff_cnt : '0;
    end

    sa_rr_ptr #(.MODULUS(NUM_STRIPES), .PTR_W(SW), .STEP_W(CW)) u_stripe_ptr (
        .clk(clk), .rst_n(rst_n), .step_i(step), .ptr_o(stripe_ptr));

    sa_rr_ptr #(.MODULUS(NUM_PORTS), .PTR_W(PW), .STEP_W(CW)) u_port_ptr (
        .clk(clk), .rst_n(rst_n), .step_i(step), .ptr_o(port_ptr));

    for (genvar g = 0; g < NUM_STRIPES; g++) begin : g_slot
        sa_slot #(
            .NUM_STRIPES(NUM_STRIPES), .NUM_PORTS(NUM_PORTS),
            .SW(SW), .PW(PW), .CW(CW), .IDX(g)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .stripe_ptr_i(stripe_ptr), .port_ptr_i(port_ptr),
            .eff_cnt_i(eff_cnt), .grant_i(grant),
            .release_i(release_i[g]),
            .want_o(want[g]), .busy_o(busy[g]), .load_o(load_o[g]),
            .tag_o(port_tag_o[g*PW +: PW]));
    end

    AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (load_o == '0)); // R5
    AST_STALL_HOLDS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ($stable(stripe_ptr) && $stable(port_ptr))); // R5
    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> ($countones(load_o) == int'(eff_cnt))); // R2
    AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt_i == '0) |-> !stall_o); // R8
endmodule

// File: tb/shadow_stripe_alloc_bench.sv
module shadow_stripe_alloc_bench;
    localparam int S  = 6;
    localparam int P  = 4;
    localparam int MX = 4;
    localparam int SW = 3;
    localparam int PW = 2;
    localparam int CW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     issue_cnt_i = '0;
    logic [S-1:0]      release_i = '0;
    logic [S-1:0]      load_o;
    logic [S*PW-1:0]   port_tag_o;
    logic              stall_o;

    int n_checks = 0;
    int n_fail   = 0;
    int m_sptr   = 0;
    int m_pptr   = 0;
    bit m_busy [S];
    bit done = 0;

    always #10 clk = ~clk;

    shadow_stripe_alloc #(.NUM_STRIPES(S), .NUM_PORTS(P), .MAX_ISSUE(MX)) u_shadow_stripe_alloc (
        .clk(clk), .rst_n(rst_n), .issue_cnt_i(issue_cnt_i), .release_i(release_i),
        .load_o(load_o), .port_tag_o(port_tag_o), .stall_o(stall_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int cnt, input logic [S-1:0] rel, input string req);
        int eff;
        logic [S-1:0] want;
        logic [S*PW-1:0] tags;
        logic stall;
        @(negedge clk);
        issue_cnt_i = CW'(cnt);
        release_i   = rel;
        #2;
        eff   = (cnt > MX) ? MX : cnt;
        want  = '0;
        tags  = '0;
        stall = 1'b0;
        for (int j = 0; j < eff; j++) begin
            want[(m_sptr + j) % S] = 1'b1;
            if (m_busy[(m_sptr + j) % S]) stall = 1'b1;
        end
        if (!stall) begin
            for (int j = 0; j < eff; j++)
                tags[((m_sptr + j) % S)*PW +: PW] = PW'((m_pptr + j) % P);
        end else begin
            want = '0;
        end
        check(req, 32'(load_o), 32'(want));
        check("R4 R10", 32'(port_tag_o), 32'(tags));
        check("R5", 32'(stall_o), 32'(stall));
        for (int i = 0; i < S; i++)
            m_busy[i] = (m_busy[i] && !rel[i]) || want[i];
        if (!stall) begin
            m_sptr = (m_sptr + eff) % S;
            m_pptr = (m_pptr + eff) % P;
        end
    endtask

    initial begin
        for (int i = 0; i < S; i++) m_busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, '0, "R1");
        step(2, '0, "R1");            // stripes 0,1 ports 0,1
        step(4, '0, "R2");            // stripes 2..5 ports 2,3,0,1
        step(1, '0, "R5");            // all busy: stall
        step(0, 6'b000011, "R6");     // release 0,1
        step(2, '0, "R6");            // stripes 0,1 ports 2,3
        step(0, 6'b111100, "R8");     // release 2..5
        step(0, 6'b111100, "R7");     // releasing free stripes: no effect
        step(3, '0, "R3");            // stripes 2,3,4 ports 0,1,2
        step(0, 6'b011111, "R6");
        step(7, '0, "R9");            // clamp to 4: stripes 5,0,1,2
        step(0, 6'b111111, "R8");
        for (int k = 0; k < 600; k++)
            step(int'($urandom % 8), S'($urandom), "R2");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule